// File: doc/BRIEF.md
# Dual-Mode Serial Shift / Event Count Port

This block holds one small register that serves two jobs. In shift mode it is a serial port: every cycle of the instruction clock it moves its contents one place to the left and takes the serial input into the lowest bit. It can drive the top bit onto the serial data output and gate a serial clock out. In count mode the same register counts down by one for every clean falling edge seen on the serial input pin. In that mode the serial data output becomes a plain software-set level and the serial clock output becomes a steady level.

A processor reaches the register with a single exchange strobe. The current contents are always visible on `acc_out`. On the clock edge where the strobe is high, the register takes `acc_in` and a clock-enable latch takes `carry_in`. That latch decides whether the serial clock output runs (shift mode) or what level it holds (count mode).

Top module: `sio_dual_port`

## Requirements
- R1: With `mode_cnt`=0 and `xchg`=0, each rising clock edge replaces the register value D with {D[2:0], `si_pin`}, so `si_pin` enters bit 0.
- R2: With `mode_cnt`=0, `so` equals register bit 3 when `so_en`=1 and is 0 when `so_en`=0. Shifting continues in both cases.
- R3: With `mode_cnt`=0, `sk` equals the clock-enable latch ANDed with `clk`. It is 0 through the low phase of `clk`, and 0 in both phases while the latch is 0.
- R4: With `mode_cnt`=1, the register decrements by one for each 1-to-0 change on `si_pin` that stays low for at least two rising edges. The new value is visible after the fourth rising edge following the fall. A low pulse caught by only one edge is not counted.
- R5: In count mode, a decrement from 0 gives 4'hF.
- R6: With `mode_cnt`=1, `so` equals `so_en`, and `sk` equals the clock-enable latch in both phases of `clk`.
- R7: `acc_out` always shows the register contents. On a rising edge with `xchg`=1, the register loads `acc_in` and the clock-enable latch loads `carry_in`.
- R8: An exchange takes priority. On an edge with `xchg`=1, no shift happens, and a decrement that falls due on that edge is dropped.
- R9: Synchronous active-low reset `rst_n` clears the register, the clock-enable latch and the input edge history, so a fall of `si_pin` that overlaps reset is never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Synchronous reset, active low |
| si_pin | input | 1 | Serial data in / event input |
| mode_cnt | input | 1 | 0 = shift mode, 1 = count mode |
| so_en | input | 1 | Shift mode: enable serial output; count mode: output level |
| xchg | input | 1 | Exchange strobe |
| acc_in | input | 4 | Value loaded on exchange |
| carry_in | input | 1 | Value loaded into clock-enable latch on exchange |
| acc_out | output | 4 | Current register contents |
| so | output | 1 | Serial data out |
| sk | output | 1 | Serial clock out |

## Verification
Shift results and exchange loads appear one rising edge after the inputs are set. A count appears four rising edges after `si_pin` falls: two edges of synchronizer, one edge of history, and one edge of register update. The bench drives inputs just after each falling edge and reads results in the clock's low phase. It checks count timing both one edge before the new value is due and on the edge where it is due. `sk` follows `clk` combinationally, so it is read a quarter period into each phase.

// File: rtl/sio_pkg.sv
// Shared definitions for the dual-mode serial shift / event count port.
// Assumes a single instruction-cycle clock domain.
package sio_pkg;
    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_COUNT = 1'b1
    } sio_mode_e;
endpackage

// File: rtl/sio_edge_det.sv
// Falling-edge qualifier for the event input.
// Synchronizes the pin through SYNC_STAGES flops, then flags an event when a
// high sample is followed by two low samples. Assumes SYNC_STAGES >= 2.
module sio_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [1:0]             hist_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // Synchronizer chain for the asynchronous pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    // Two-deep history of synchronized samples
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[0], synced};
    end

    // Event: older sample high, last two samples low
    always_comb begin
        fall_evt = hist_q[1] & ~hist_q[0] & ~synced;
    end
endmodule

// File: rtl/sio_core.sv
// Storage for the dual-mode register and the clock-enable latch.
// Shift mode: left shift with serial input into bit 0 every cycle.
// Count mode: decrement (wrapping) on each qualified event.
// An exchange load wins over both. Assumes si is stable around the edge.
module sio_core
    import sio_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sio_mode_e        mode,
    input  logic             si,
    input  logic             fall_evt,
    input  logic             xchg,
    input  logic [WIDTH-1:0] load_val,
    input  logic             carry_in,
    output logic [WIDTH-1:0] data_q,
    output logic             skl_q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] data_nxt;

    // Next-state selection with exchange priority
    always_comb begin
        data_nxt = data_q;
        if (xchg)                     data_nxt = load_val;
        else if (mode == MODE_SHIFT)  data_nxt = {data_q[WIDTH-2:0], si};
        else if (fall_evt)            data_nxt = data_q - ONE;
    end

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_nxt;
    end

    // Clock-enable latch, loaded only on exchange
    always_ff @(posedge clk) begin
        if (!rst_n)    skl_q <= 1'b0;
        else if (xchg) skl_q <= carry_in;
    end
endmodule

// File: rtl/sio_outsel.sv
// Output selection for serial data and serial clock by mode.
// Purely combinational; sk follows clk so it carries the cycle clock when gated.
module sio_outsel
    import sio_pkg::*;
(
    input  logic      clk,
    input  sio_mode_e mode,
    input  logic      so_en,
    input  logic      msb,
    input  logic      skl,
    output logic      so,
    output logic      sk
);
    // Mode table for the two outputs
    always_comb begin
        if (mode == MODE_COUNT) begin
            so = so_en;
            sk = skl;
        end else begin
            so = so_en & msb;
            sk = skl & clk;
        end
    end
endmodule

// File: rtl/sio_dual_port.sv
// Top of the dual-mode serial shift / event count port.
// Wires the event qualifier, register core and output selector together.
// Assumes one clock domain; si_pin may be asynchronous in count mode only.
module sio_dual_port
    import sio_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             si_pin,
    input  logic             mode_cnt,
    input  logic             so_en,
    input  logic             xchg,
    input  logic [WIDTH-1:0] acc_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] acc_out,
    output logic             so,
    output logic             sk
);
    sio_mode_e        mode;
    logic             fall_evt;
    logic [WIDTH-1:0] data_q;
    logic             skl_q;

    assign mode    = sio_mode_e'(mode_cnt);
    assign acc_out = data_q;

    sio_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (si_pin),
        .fall_evt (fall_evt)
    );

    sio_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .si       (si_pin),
        .fall_evt (fall_evt),
        .xchg     (xchg),
        .load_val (acc_in),
        .carry_in (carry_in),
        .data_q   (data_q),
        .skl_q    (skl_q)
    );

    sio_outsel u_out (
        .clk   (clk),
        .mode  (mode),
        .so_en (so_en),
        .msb   (data_q[WIDTH-1]),
        .skl   (skl_q),
        .so    (so),
        .sk    (sk)
    );
endmodule

// File: rtl/sio_dual_port_chk.sv
// Port-level property checker for sio_dual_port, attached by bind.
module sio_dual_port_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             si_pin,
    input logic             mode_cnt,
    input logic             so_en,
    input logic             xchg,
    input logic [WIDTH-1:0] acc_in,
    input logic             carry_in,
    input logic [WIDTH-1:0] acc_out,
    input logic             so,
    input logic             sk
);
    assert_shift_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cnt && !xchg) |=> acc_out == {$past(acc_out[WIDTH-2:0]), $past(si_pin)});

    assert_so_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cnt |-> so == (so_en & acc_out[WIDTH-1]));

    assert_sk_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cnt |-> !sk);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cnt && !xchg) |=> (acc_out == $past(acc_out)) || (acc_out == $past(acc_out) - WIDTH'(1)));

    assert_so_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cnt |-> so == so_en);

    assert_sk_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg && mode_cnt) |=> (!mode_cnt || sk == $past(carry_in)));

    assert_xchg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xchg |=> acc_out == $past(acc_in));
endmodule

bind sio_dual_port sio_dual_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .si_pin   (si_pin),
    .mode_cnt (mode_cnt),
    .so_en    (so_en),
    .xchg     (xchg),
    .acc_in   (acc_in),
    .carry_in (carry_in),
    .acc_out  (acc_out),
    .so       (so),
    .sk       (sk)
);

// File: tb/sim_sio_dual_port.sv
module sim_sio_dual_port;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       si_pin = 1'b1;
    logic       mode_cnt = 1'b0;
    logic       so_en = 1'b0;
    logic       xchg = 1'b0;
    logic [3:0] acc_in = 4'h0;
    logic       carry_in = 1'b0;
    logic [3:0] acc_out;
    logic       so;
    logic       sk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    sio_dual_port u0 (
        .clk(clk), .rst_n(rst_n), .si_pin(si_pin), .mode_cnt(mode_cnt),
        .so_en(so_en), .xchg(xchg), .acc_in(acc_in), .carry_in(carry_in),
        .acc_out(acc_out), .so(so), .sk(sk)
    );

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // advance to just after the next falling edge
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load(input logic [3:0] v, input logic c);
        xchg = 1'b1; acc_in = v; carry_in = c;
        step();
        xchg = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mode_cnt = 1'b1; so_en = 1'b0;
        wait_n(3);
        chk("R9 reset register", acc_out, 4'h0);
        chk("R9 reset latch sk", {3'b0, sk}, 4'h0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_shift();
        logic [3:0] exp;
        logic [3:0] bits;
        mode_cnt = 1'b0; so_en = 1'b1;
        load(4'hA, 1'b0);
        chk("R7 exchange load", acc_out, 4'hA);
        exp = 4'hA;
        bits = 4'b1101;
        for (int i = 0; i < 4; i++) begin
            si_pin = bits[i];
            exp = {exp[2:0], bits[i]};
            step();
            chk("R1 shift step", acc_out, exp);
            chk("R2 so msb", {3'b0, so}, {3'b0, exp[3]});
        end
    endtask

    task automatic t_so_off();
        logic [3:0] exp;
        mode_cnt = 1'b0; so_en = 1'b0;
        load(4'hF, 1'b0);
        exp = 4'hF;
        for (int i = 0; i < 3; i++) begin
            si_pin = 1'b0;
            exp = {exp[2:0], 1'b0};
            step();
            chk("R2 so held 0", {3'b0, so}, 4'h0);
            chk("R2 shift continues", acc_out, exp);
        end
    endtask

    task automatic t_sk_shift();
        mode_cnt = 1'b0;
        load(4'h0, 1'b1);
        chk("R3 sk low phase", {3'b0, sk}, 4'h0);
        @(posedge clk); #(CLK_P/4);
        chk("R3 sk high phase latch set", {3'b0, sk}, 4'h1);
        step();
        load(4'h0, 1'b0);
        @(posedge clk); #(CLK_P/4);
        chk("R3 sk high phase latch clear", {3'b0, sk}, 4'h0);
        step();
    endtask

    task automatic t_count();
        mode_cnt = 1'b1; si_pin = 1'b1;
        load(4'h3, 1'b0);
        wait_n(4);
        si_pin = 1'b0;
        wait_n(3);
        chk("R4 not yet counted", acc_out, 4'h3);
        step();
        chk("R4 counted on 4th edge", acc_out, 4'h2);
        wait_n(3);
        chk("R4 single count per fall", acc_out, 4'h2);
        si_pin = 1'b1;
        wait_n(4);
        si_pin = 1'b0;
        step();
        si_pin = 1'b1;
        wait_n(6);
        chk("R4 short pulse ignored", acc_out, 4'h2);
    endtask

    task automatic t_wrap();
        mode_cnt = 1'b1; si_pin = 1'b1;
        load(4'h0, 1'b0);
        wait_n(4);
        si_pin = 1'b0;
        wait_n(4);
        chk("R5 wrap to F", acc_out, 4'hF);
        si_pin = 1'b1;
        wait_n(4);
    endtask

    task automatic t_cnt_out();
        mode_cnt = 1'b1; so_en = 1'b1;
        load(4'h0, 1'b1);
        chk("R6 so equals so_en", {3'b0, so}, 4'h1);
        chk("R6 sk low phase", {3'b0, sk}, 4'h1);
        @(posedge clk); #(CLK_P/4);
        chk("R6 sk high phase", {3'b0, sk}, 4'h1);
        step();
        so_en = 1'b0;
        #1;
        chk("R6 so follows so_en", {3'b0, so}, 4'h0);
        load(4'h0, 1'b0);
        chk("R6 sk follows latch", {3'b0, sk}, 4'h0);
    endtask

    task automatic t_prio();
        mode_cnt = 1'b0; si_pin = 1'b1;
        load(4'h4, 1'b0);
        load(4'h6, 1'b0);
        chk("R8 exchange beats shift", acc_out, 4'h6);
        mode_cnt = 1'b1; si_pin = 1'b1;
        load(4'h5, 1'b0);
        wait_n(4);
        si_pin = 1'b0;
        wait_n(3);
        load(4'h9, 1'b0);
        chk("R8 exchange beats count", acc_out, 4'h9);
        wait_n(3);
        chk("R8 dropped count stays dropped", acc_out, 4'h9);
        si_pin = 1'b1;
        wait_n(4);
    endtask

    task automatic t_reset_edge();
        mode_cnt = 1'b1; si_pin = 1'b1;
        wait_n(4);
        si_pin = 1'b0; rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        wait_n(6);
        chk("R9 fall across reset not counted", acc_out, 4'h0);
        si_pin = 1'b1;
        wait_n(2);
    endtask

    initial begin
        while (cycles < 5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_shift();
        t_so_off();
        t_sk_shift();
        t_count();
        t_wrap();
        t_cnt_out();
        t_prio();
        t_reset_edge();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule